// File: doc/BRIEF.md
# Password-Gated Fractional Clock Generator Channel

This block is one channel of a general-purpose clock generator. Software programs it through two 32-bit registers: a control word and a divisor word. A write lands only when its top byte carries the unlock key 0x5A. The control word picks which of four source clocks feeds the divider. It also enables or kills the output and selects the noise-shaping order. It reports whether the divider is running. The divisor word holds a 12-bit integer part and a 12-bit fractional part.

The sources arrive as per-cycle tick strobes in the system clock domain, so the divider counts source edges synchronously. With shaping order 0 the output period is exactly the integer divisor in source ticks. With a non-zero order, a 12-bit phase accumulator adds the fraction once per output period. A carry lengthens that period by one tick, which gives an average period of integer plus fraction/4096.

Software must kill the channel and wait for busy to clear before it changes the divisor, the source or the order. While the channel runs, only the enable and kill bits accept writes. A stop always takes effect at the end of a low phase, so the output never emits a runt pulse.

Top module: `frac_clkgen`

## Requirements
- R1: A register write whose bits 31:24 differ from 0x5A changes no register; readback is unchanged.
- R2: Control readback layout: bits 3:0 source code, bit 4 enable, bit 5 kill, bit 7 busy (read-only), bits 10:9 shaping order, all other bits 0. After a keyed write, the writable fields read back as written.
- R3: Divisor readback layout: bits 23:12 integer part, bits 11:0 fractional part, bits 31:24 read 0. After a keyed write, both parts read back as written.
- R4: While busy is 1, divisor writes are ignored, and control writes change only enable and kill.
- R5: Source codes 1, 5, 6 and 7 select src_tick bits 0, 1, 2 and 3. When the channel is idle with enable 1, kill 0, a valid source and an integer part of 2 or more, busy reads 1 one cycle later.
- R6: With order 0, every output period lasts exactly the integer part in selected-source ticks. The high phase lasts floor(period/2) ticks and comes first. The fraction has no effect.
- R7: With order 1, 2 or 3, period k lasts the integer part plus the carry out of acc_k + fraction, where acc_0 = 0 and acc_{k+1} = (acc_k + fraction) mod 4096. The high phase lasts floor(period/2) ticks.
- R8: After kill is set or enable is cleared, busy falls only at the end of a complete low phase: the last period has its full length. The output is low whenever busy is 0.
- R9: A source code outside {1,5,6,7}, or an integer part below 2, keeps busy at 0 and the output low even when enabled.
- R10: After reset both registers read 0, busy is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write data including unlock byte |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Combinational register readback |
| src_tick | input | 4 | Tick strobes of the four source clocks |
| clk_out | output | 1 | Divided clock output |

## Verification
The hazardous overlap is a stop request, or a blocked reconfiguration write, landing in the same cycle that the divider wraps a period. The bench issues kills, enable clears and busy-time writes at arbitrary points while random source tick patterns run, so some of them meet a wrap edge. It judges the result by measuring every period and high phase in selected-source ticks against a bench model of the accumulator. The final period before busy drops must be full length, and readback after a blocked write must keep the old configuration.

// File: rtl/frac_clkgen.sv
module frac_clkgen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  input  logic [3:0]  src_tick,
  output logic        clk_out
);
  localparam logic [7:0] KEY = 8'h5A;

  logic [3:0]  src_q;
  logic [1:0]  mash_q;
  logic        enab_q, kill_q, busy_q;
  logic [11:0] divi_q, divf_q, acc_q;
  logic [12:0] cnt_q;
  logic        tick, src_ok;

  always_comb begin
    tick   = 1'b0;
    src_ok = 1'b1;
    case (src_q)
      4'd1:    tick = src_tick[0];
      4'd5:    tick = src_tick[1];
      4'd6:    tick = src_tick[2];
      4'd7:    tick = src_tick[3];
      default: src_ok = 1'b0;
    endcase
  end

  wire        key_ok  = wr_en && (wr_data[31:24] == KEY);
  wire [12:0] acc_sum = {1'b0, acc_q} + {1'b0, divf_q};
  wire        stretch = (mash_q != 2'd0) && acc_sum[12];
  wire [12:0] period  = {1'b0, divi_q} + {12'd0, stretch};
  wire [12:0] hi_len  = period >> 1;
  wire        cfg_ok  = src_ok && (divi_q >= 12'd2);
  wire        start   = !busy_q && enab_q && !kill_q && cfg_ok;
  wire        wrap    = busy_q && tick && (cnt_q == period - 13'd1);
  wire        stop    = !enab_q || kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; mash_q <= '0; enab_q <= 1'b0; kill_q <= 1'b0;
      busy_q <= 1'b0; divi_q <= '0; divf_q <= '0; acc_q <= '0; cnt_q <= '0;
    end else begin
      if (key_ok && !wr_sel) begin
        enab_q <= wr_data[4];
        kill_q <= wr_data[5];
        if (!busy_q) begin
          src_q  <= wr_data[3:0];
          mash_q <= wr_data[10:9];
        end
      end
      if (key_ok && wr_sel && !busy_q) begin
        divi_q <= wr_data[23:12];
        divf_q <= wr_data[11:0];
      end
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        acc_q  <= '0;
      end else if (busy_q && tick) begin
        if (wrap) begin
          cnt_q <= '0;
          if (mash_q != 2'd0) acc_q <= acc_sum[11:0];
          if (stop) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 13'd1;
        end
      end
    end
  end

  assign clk_out = busy_q && (cnt_q < hi_len);
  assign rd_data = rd_sel ? {8'h00, divi_q, divf_q}
                          : {21'd0, mash_q, 1'b0, busy_q, 1'b0, kill_q, enab_q, src_q};
endmodule

module frac_clkgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        busy_q,
  input logic        clk_out,
  input logic        cfg_ok,
  input logic [3:0]  src_q,
  input logic [1:0]  mash_q,
  input logic [11:0] divi_q,
  input logic [11:0] divf_q
);
  AST_BAD_KEY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:24] != 8'h5A) |=> ($stable(divi_q) && $stable(divf_q) && $stable(src_q) && $stable(mash_q))); // R1
  AST_DIV_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(divi_q) && $stable(divf_q))); // R4
  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(src_q) && $stable(mash_q))); // R4
  AST_OUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !clk_out); // R8
  AST_STOP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !$past(clk_out)); // R8
  AST_NO_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !cfg_ok) |=> !busy_q); // R9
endmodule

bind frac_clkgen frac_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .busy_q(busy_q), .clk_out(clk_out), .cfg_ok(cfg_ok),
  .src_q(src_q), .mash_q(mash_q), .divi_q(divi_q), .divf_q(divf_q)
);

// File: tb/tb_frac_clkgen.sv
module tb_frac_clkgen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  src_tick = '0;
  logic        clk_out;

  frac_clkgen dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_bit = 0, m_divi = 2, m_divf = 0, m_mash = 0;
  bit mon = 1'b0, p_out = 1'b0, p_busy = 1'b0;
  int ticks = 0, pcur = 0, acc = 0, nper = 0;
  int seed_sink;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int per_of(int a);
    return m_divi + (((m_mash != 0) && (a + m_divf >= 4096)) ? 1 : 0);
  endfunction

  function automatic logic [31:0] ctl_word(int src, bit en, bit kl, bit bsy, int mash);
    return {21'd0, 2'(mash), 1'b0, bsy, 1'b0, kl, en, 4'(src)};
  endfunction

  function automatic int code_of(int b);
    case (b) 0: return 1; 1: return 5; 2: return 6; default: return 7; endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mon = 0; p_out = 0; p_busy = 0; ticks = 0; src_tick = '0;
    end else begin
      bit cb;
      cb = rd_sel ? p_busy : rd_data[7];
      if (src_tick[m_bit]) ticks++;
      if (!p_busy && cb) begin
        acc = 0; pcur = per_of(0); ticks = 0; nper = 0; mon = 1;
      end else if (mon) begin
        if (clk_out && !p_out) begin
          chk(ticks == pcur, (m_mash != 0) ? "R7 period" : "R6 period", ticks, pcur);
          if (m_mash != 0) acc = (acc + m_divf) % 4096;
          pcur = per_of(acc); ticks = 0; nper++;
        end
        if (!clk_out && p_out)
          chk(ticks == pcur / 2, (m_mash != 0) ? "R7 high" : "R6 high", ticks, pcur / 2);
        if (p_busy && !cb) begin
          chk(ticks == pcur, "R8 last period full", ticks, pcur);
          mon = 0;
        end
      end
      p_out = clk_out; p_busy = cb;
      src_tick = 4'($urandom);
    end
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(bit sel, output logic [31:0] v);
    @(negedge clk); #2 rd_sel = sel; #1 v = rd_data; #1 rd_sel = 1'b0;
  endtask

  task automatic wait_busy(bit val);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(1'b0, v);
      if (v[7] == val) return;
    end
    chk(0, "R8 busy wait timeout", 0, int'(val));
  endtask

  task automatic run(int b, int divi, int divf, int mash, int nps, bit by_enab);
    logic [31:0] v;
    int src = code_of(b);
    wr(0, 32'h5A00_0020);
    wait_busy(0);
    m_bit = b; m_divi = divi; m_divf = divf; m_mash = mash;
    wr(1, {8'h5A, 12'(divi), 12'(divf)});
    wr(0, 32'h5A00_0000 | ctl_word(src, 0, 0, 0, mash));
    wr(0, 32'h5A00_0000 | ctl_word(src, 1, 0, 0, mash));
    rd(0, v);
    chk(v[7] == 1'b1, "R5 busy after enable", int'(v[7]), 1);
    for (int i = 0; i < 50000 && nper < nps; i++) @(negedge clk);
    chk(nper >= nps, "R6 R7 periods seen", nper, nps);
    wr(1, {8'h5A, 12'd9, 12'd9});
    rd(1, v);
    chk(v == {8'h00, 12'(divi), 12'(divf)}, "R4 divisor held", v, {8'h00, 12'(divi), 12'(divf)});
    wr(0, 32'h5A00_0000 | ctl_word(src ^ 2, 1, 0, 0, mash ^ 1));
    rd(0, v);
    chk(v == ctl_word(src, 1, 0, 1, mash), "R4 control held", v, ctl_word(src, 1, 0, 1, mash));
    if (by_enab) wr(0, 32'h5A00_0000 | ctl_word(src, 0, 0, 0, mash));
    else         wr(0, 32'h5A00_0000 | ctl_word(src, 1, 1, 0, mash));
    wait_busy(0);
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R8 output low after stop", int'(clk_out), 0);
  endtask

  initial begin
    logic [31:0] v;
    seed_sink = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, v); chk(v == 0, "R10 control reset", v, 0);
    rd(1, v); chk(v == 0, "R10 divisor reset", v, 0);
    chk(clk_out == 1'b0, "R10 output low", int'(clk_out), 0);

    wr(1, 32'h1100_5123);
    rd(1, v); chk(v == 0, "R1 divisor bad key", v, 0);
    wr(0, 32'hA500_0211);
    rd(0, v); chk(v == 0, "R1 control bad key", v, 0);

    wr(1, 32'h5A00_5123);
    rd(1, v); chk(v == 32'h0000_5123, "R3 divisor layout", v, 32'h0000_5123);
    wr(1, 32'h5AFF_F00A);
    rd(1, v); chk(v == 32'h00FF_F00A, "R3 divisor extremes", v, 32'h00FF_F00A);
    wr(0, 32'h5A00_0000 | ctl_word(5, 0, 1, 0, 3));
    rd(0, v); chk(v == ctl_word(5, 0, 1, 0, 3), "R2 control layout", v, ctl_word(5, 0, 1, 0, 3));

    wr(1, 32'h5A00_4000);
    wr(0, 32'h5A00_0000 | ctl_word(2, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(0, v); chk(v[7] == 0 && clk_out == 0, "R9 bad source idle", int'(v[7]), 0);
    wr(1, 32'h5A00_1000);
    wr(0, 32'h5A00_0000 | ctl_word(1, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(0, v); chk(v[7] == 0 && clk_out == 0, "R9 divisor below 2 idle", int'(v[7]), 0);

    run(0, 2, 0, 0, 20, 0);
    run(1, 3, 4095, 0, 20, 1);
    run(2, 7, 0, 0, 12, 0);
    run(3, 2, 4095, 1, 40, 0);
    run(0, 3, 1, 2, 20, 1);
    run(1, 2, 2048, 1, 64, 0);
    for (int k = 0; k < 6; k++)
      run(int'($urandom % 4), 2 + int'($urandom % 39), int'($urandom % 4096),
          int'($urandom % 4), 15, bit'($urandom % 2));

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule